// File: doc/BRIEF.md
# Variable-Length Instruction Fetch Sequencer

This block sits between a byte-wide instruction memory and a simple decoder. It requests one byte at a time, looks at the first byte of each instruction to decide how many operand bytes follow (none, one or two), and collects the whole instruction. It then presents the opcode, an immediate byte and a 16-bit target address to the decoder, together with a valid flag. The decoder answers with a ready flag. While an instruction is offered and not taken, the sequencer holds it and stops fetching.

The length comes from fixed bit patterns in the opcode rather than from any length field. Three byte values stop the machine. When one of them is fetched, the sequencer stops requesting bytes and stays idle until reset. The execution side can move the fetch pointer after a taken branch. Any instruction that is partly collected or waiting to be taken is then dropped.

The memory port is a request/response pair. A byte counts as accepted in any cycle where the request and the ready are both high, and the data is read in that same cycle.

Top module: `instr_fetch_seq`

## Requirements
- R1: After synchronous reset, `ins_valid`, `halted` and `mem_req` are low and `mem_addr` is 0. The first request, one cycle later, reads address 0.
- R2: An opcode with bits [7:6] = 00 and bits [2:0] = 100 or 110 is followed by one byte. That byte is issued on `ins_imm`, and `ins_addr` is issued as 0.
- R3: An opcode with bits [7:6] = 01 and bit 0 = 0 is followed by two bytes, low byte first. These are issued as `ins_addr` = {third byte, second byte}, and `ins_imm` is issued as 0.
- R4: Any other opcode that is not a halt (for example 0x80, 0x41, 0xC1 or 0x07) is a single byte, issued with `ins_imm` = 0 and `ins_addr` = 0.
- R5: The byte values 0x00, 0x01 and 0xFF are halts. They are never issued. After one is accepted, `halted` goes high and stays high until reset, `mem_req` stays low, and `redirect_en` has no effect.
- R6: `mem_addr` advances by one for every accepted byte and wraps modulo 2^AW. While `mem_req` is high and `mem_rdy` is low, `mem_addr` holds.
- R7: While `ins_valid` is high and `dn_ready` is low, the opcode, immediate and address hold steady and `ins_valid` stays high. An instruction is taken, and `ins_valid` falls, at the first edge where `dn_ready` is high.
- R8: When `redirect_en` is high (and the sequencer has not halted), `mem_addr` equals `redirect_addr` after the next edge and `ins_valid` is low. Any partly collected or waiting instruction is dropped, including a byte accepted at that same edge.
- R9: `mem_req` is low whenever `ins_valid` is high, so no byte is fetched while an instruction is being offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_req | output | 1 | Byte fetch request |
| mem_addr | output | AW | Fetch address |
| mem_rdy | input | 1 | Memory ready; `mem_rdata` is valid in this cycle |
| mem_rdata | input | 8 | Byte read from memory |
| redirect_en | input | 1 | Load a new fetch address and drop any instruction in progress |
| redirect_addr | input | AW | New fetch address |
| ins_valid | output | 1 | A complete instruction is offered |
| ins_opcode | output | 8 | Opcode byte |
| ins_imm | output | 8 | Immediate byte, or 0 |
| ins_addr | output | 16 | Assembled target address, or 0 |
| dn_ready | input | 1 | Decoder takes the offered instruction |
| halted | output | 1 | A halt byte has been fetched |

## Verification
A redirect can land on the same edge as either a memory byte acceptance or a waiting instruction. The bench provokes the first case by holding the sequencer between the first and second bytes of a jump, then raising `redirect_en` while `mem_rdy` is high. It provokes the second case by keeping `dn_ready` low while an instruction waits and then redirecting. In both cases the scoreboard must see only the instructions found at the new address, and the fetch address must equal the redirect target one edge later. A further redirect to the top address checks that a two-byte instruction wraps correctly to address 0.

// File: rtl/fetch_pkg.sv
package fetch_pkg;

  localparam int BYTE_W = 8;
  localparam int TGT_W  = 16;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_OP,
    ST_BYTE2,
    ST_BYTE3,
    ST_ISSUE,
    ST_HALTED
  } seq_state_t;

  typedef enum logic [1:0] {
    LEN_ONE,
    LEN_TWO,
    LEN_THREE,
    LEN_STOP
  } len_class_t;

  typedef struct packed {
    logic [BYTE_W-1:0] opcode;
    logic [BYTE_W-1:0] imm;
    logic [TGT_W-1:0]  addr;
  } instr_word_t;

endpackage

// File: rtl/ifs_len_decode.sv
module ifs_len_decode
  import fetch_pkg::*;
(
  input  logic [BYTE_W-1:0] op,
  output len_class_t        cls
);

  logic is_stop, is_imm, is_far;

  always_comb begin
    is_stop = (op[BYTE_W-1:1] == '0) || (op == {BYTE_W{1'b1}});
    is_imm  = (op[7:6] == 2'b00) && op[2] && !op[0];
    is_far  = (op[7:6] == 2'b01) && !op[0];
    if (is_stop)     cls = LEN_STOP;
    else if (is_far) cls = LEN_THREE;
    else if (is_imm) cls = LEN_TWO;
    else             cls = LEN_ONE;
  end

endmodule

// File: rtl/ifs_fetch_ptr.sv
module ifs_fetch_ptr #(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          load,
  input  logic [AW-1:0] load_addr,
  output logic [AW-1:0] ptr
);

  always_ff @(posedge clk) begin
    if (rst)       ptr <= '0;
    else if (load) ptr <= load_addr;
    else if (step) ptr <= ptr + 1'b1;
  end

  // R6
  ptr_step_chk: assert property (@(posedge clk) disable iff (rst)
    (step && !load) |=> ptr == AW'($past(ptr) + 1'b1));

endmodule

// File: rtl/ifs_assemble.sv
module ifs_assemble
  import fetch_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_op,
  input  logic              wr_imm,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [BYTE_W-1:0] din,
  output instr_word_t       word
);

  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
    end else if (wr_op) begin
      word.opcode <= din;
      word.imm    <= '0;
      word.addr   <= '0;
    end else begin
      if (wr_imm) word.imm <= din;
      if (wr_lo)  word.addr[BYTE_W-1:0] <= din;
      if (wr_hi)  word.addr[TGT_W-1:BYTE_W] <= din;
    end
  end

endmodule

// File: rtl/instr_fetch_seq.sv
module instr_fetch_seq
  import fetch_pkg::*;
#(
  parameter int AW = 14
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_rdy,
  input  logic [7:0]    mem_rdata,
  input  logic          redirect_en,
  input  logic [AW-1:0] redirect_addr,
  output logic          ins_valid,
  output logic [7:0]    ins_opcode,
  output logic [7:0]    ins_imm,
  output logic [15:0]   ins_addr,
  input  logic          dn_ready,
  output logic          halted
);

  seq_state_t  state, nxt;
  len_class_t  op_cls, cls_q;
  instr_word_t word;
  logic        accept, kill;

  assign mem_req   = (state == ST_OP) || (state == ST_BYTE2) || (state == ST_BYTE3);
  assign ins_valid = (state == ST_ISSUE);
  assign halted    = (state == ST_HALTED);
  assign accept    = mem_req && mem_rdy;
  assign kill      = redirect_en && (state != ST_HALTED);

  ifs_len_decode u_dec (
    .op  (mem_rdata),
    .cls (op_cls)
  );

  ifs_fetch_ptr #(.AW(AW)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .step      (accept),
    .load      (kill),
    .load_addr (redirect_addr),
    .ptr       (mem_addr)
  );

  ifs_assemble u_asm (
    .clk    (clk),
    .rst    (rst),
    .wr_op  ((state == ST_OP) && accept && !kill),
    .wr_imm ((state == ST_BYTE2) && accept && !kill && (cls_q == LEN_TWO)),
    .wr_lo  ((state == ST_BYTE2) && accept && !kill && (cls_q == LEN_THREE)),
    .wr_hi  ((state == ST_BYTE3) && accept && !kill),
    .din    (mem_rdata),
    .word   (word)
  );

  assign ins_opcode = word.opcode;
  assign ins_imm    = word.imm;
  assign ins_addr   = word.addr;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:  nxt = ST_OP;
      ST_OP:
        if (accept) begin
          case (op_cls)
            LEN_STOP: nxt = ST_HALTED;
            LEN_ONE:  nxt = ST_ISSUE;
            default:  nxt = ST_BYTE2;
          endcase
        end
      ST_BYTE2: if (accept) nxt = (cls_q == LEN_THREE) ? ST_BYTE3 : ST_ISSUE;
      ST_BYTE3: if (accept) nxt = ST_ISSUE;
      ST_ISSUE: if (dn_ready) nxt = ST_OP;
      default:  nxt = ST_HALTED;
    endcase
    if (kill) nxt = ST_OP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cls_q <= LEN_ONE;
    end else begin
      state <= nxt;
      if ((state == ST_OP) && accept) cls_q <= op_cls;
    end
  end

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rdy && !redirect_en) |=> $stable(mem_addr));

  // R7
  issue_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && !dn_ready && !redirect_en) |=>
      (ins_valid && $stable(ins_opcode) && $stable(ins_imm) && $stable(ins_addr)));

  // R5
  halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    halted |=> (halted && !mem_req && !ins_valid));

  // R8
  redirect_chk: assert property (@(posedge clk) disable iff (rst)
    (redirect_en && !halted) |=> (mem_addr == $past(redirect_addr) && !ins_valid));

  // R9
  no_fetch_in_issue_chk: assert property (@(posedge clk) disable iff (rst)
    ins_valid |-> !mem_req);

endmodule

// File: tb/instr_fetch_seq_test.sv
`timescale 1ns/100ps
module instr_fetch_seq_test;

  localparam int AW = 14;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          mem_req;
  logic [AW-1:0] mem_addr;
  logic          mem_rdy;
  logic [7:0]    mem_rdata;
  logic          redirect_en = 1'b0;
  logic [AW-1:0] redirect_addr = '0;
  logic          ins_valid;
  logic [7:0]    ins_opcode, ins_imm;
  logic [15:0]   ins_addr;
  logic          dn_ready;
  logic          halted;

  logic [7:0]  mem [64];
  logic [31:0] expq [$];
  logic        auto_mode = 1'b0;
  logic        man_rdy = 1'b0, man_dn = 1'b1;
  logic [15:0] lfsr = 16'hACE1;
  int          n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  assign mem_rdata = mem[mem_addr[5:0]];
  assign mem_rdy   = auto_mode ? (lfsr[0] | lfsr[3]) : man_rdy;
  assign dn_ready  = auto_mode ? (lfsr[5] | lfsr[9]) : man_dn;

  always @(posedge clk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  end

  instr_fetch_seq #(.AW(AW)) uut (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rdy(mem_rdy), .mem_rdata(mem_rdata), .redirect_en(redirect_en),
    .redirect_addr(redirect_addr), .ins_valid(ins_valid), .ins_opcode(ins_opcode),
    .ins_imm(ins_imm), .ins_addr(ins_addr), .dn_ready(dn_ready), .halted(halted)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input logic [7:0] op);
    if (op[7:6] == 2'b01 && !op[0]) return "R3";
    if (op[7:6] == 2'b00 && op[2] && !op[0]) return "R2";
    return "R4";
  endfunction

  // monitor: compares every taken instruction with the scoreboard queue
  always @(negedge clk) begin
    if (!rst && ins_valid && dn_ready) begin
      if (expq.size() == 0) begin
        chk(1'b0, "R8", "unexpected issue", {ins_opcode, ins_imm, ins_addr}, 32'h0);
      end else begin
        logic [31:0] e;
        e = expq.pop_front();
        chk({ins_opcode, ins_imm, ins_addr} == e, tag_of(e[31:24]), "issued instruction",
            {ins_opcode, ins_imm, ins_addr}, e);
      end
    end
  end

  always @(posedge clk) begin
    if (n_chk >= 0 && $time > 400000) begin
      chk(1'b0, "R1", "watchdog expired", 32'h0, 32'h1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic put(input int a, input logic [7:0] b);
    mem[a % 64] = b;
  endtask

  task automatic push_exp(input logic [7:0] op, input logic [7:0] imm, input logic [15:0] ad);
    expq.push_back({op, imm, ad});
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    redirect_en = 1'b0;
    repeat (3) step();
    rst = 1'b0;
  endtask

  task automatic wait_halt(input string req);
    int n = 0;
    while (!halted && n < 3000) begin step(); n++; end
    @(negedge clk);
    chk(halted, req, "halted after halt byte", {31'h0, halted}, 32'h1);
  endtask

  initial begin
    clear_mem();
    // main program with random stalls on both sides
    put(0, 8'h80);                        push_exp(8'h80, 8'h00, 16'h0000);
    put(1, 8'h04); put(2, 8'h5A);         push_exp(8'h04, 8'h5A, 16'h0000);
    put(3, 8'h3E); put(4, 8'h11);         push_exp(8'h3E, 8'h11, 16'h0000);
    put(5, 8'h44); put(6, 8'h34); put(7, 8'h12); push_exp(8'h44, 8'h00, 16'h1234);
    put(8, 8'h42); put(9, 8'hCD); put(10, 8'hAB); push_exp(8'h42, 8'h00, 16'hABCD);
    put(11, 8'h41);                       push_exp(8'h41, 8'h00, 16'h0000);
    put(12, 8'hC1);                       push_exp(8'hC1, 8'h00, 16'h0000);
    put(13, 8'h07);                       push_exp(8'h07, 8'h00, 16'h0000);
    put(14, 8'h7E); put(15, 8'h01); put(16, 8'h02); push_exp(8'h7E, 8'h00, 16'h0201);
    put(17, 8'h2C); put(18, 8'h99);       push_exp(8'h2C, 8'h99, 16'h0000);
    put(19, 8'h00);
    man_rdy = 1'b0;
    do_reset();
    @(negedge clk);
    // R1 reset state
    chk(!ins_valid && !halted && !mem_req, "R1", "outputs idle after reset",
        {29'h0, ins_valid, halted, mem_req}, 32'h0);
    chk(mem_addr == 0, "R1", "fetch address after reset", 32'(mem_addr), 32'h0);
    step();
    @(negedge clk);
    chk(mem_req && mem_addr == 0, "R1", "first request at address 0",
        {mem_req, 15'h0, 16'(mem_addr)}, 32'h80000000);
    step();
    auto_mode = 1'b1;
    wait_halt("R5");
    chk(expq.size() == 0, "R2", "all main-program instructions issued", expq.size(), 32'h0);
    // R6: 20 bytes accepted, halt at 19
    chk(mem_addr == 20, "R6", "fetch address after main program", 32'(mem_addr), 32'd20);
    auto_mode = 1'b0;

    // redirect on the same edge as a byte acceptance (mid-instruction)
    clear_mem(); expq.delete();
    put(0, 8'h44); put(1, 8'h55); put(2, 8'h66);
    put(20, 8'h06); put(21, 8'h77); put(22, 8'h01);
    push_exp(8'h06, 8'h77, 16'h0000);
    man_rdy = 1'b0; man_dn = 1'b1;
    do_reset();
    step();                 // now in opcode state
    man_rdy = 1'b1;
    step();                 // opcode 0x44 accepted, waiting for low byte
    redirect_en = 1'b1; redirect_addr = 14'd20;
    step();
    redirect_en = 1'b0;
    @(negedge clk);
    chk(mem_addr == 20, "R8", "fetch address after redirect", 32'(mem_addr), 32'd20);
    chk(!ins_valid, "R8", "no issue after mid-instruction redirect", {31'h0, ins_valid}, 32'h0);
    step();
    wait_halt("R5");
    chk(expq.size() == 0, "R8", "only target instruction issued", expq.size(), 32'h0);

    // redirect while an instruction waits, then 0xFF halt
    clear_mem(); expq.delete();
    put(0, 8'h80); put(1, 8'hC8);
    put(30, 8'h2C); put(31, 8'h99); put(32, 8'hFF);
    man_rdy = 1'b1; man_dn = 1'b0;
    do_reset();
    begin
      int n = 0;
      while (!ins_valid && n < 50) begin step(); n++; end
    end
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(ins_valid && ins_opcode == 8'h80, "R7", "instruction held while not taken",
          {ins_valid, 23'h0, ins_opcode}, 32'h80000080);
      chk(!mem_req && mem_addr == 1, "R9", "no fetch while instruction waits",
          {mem_req, 15'h0, 16'(mem_addr)}, 32'h1);
      step();
    end
    push_exp(8'h2C, 8'h99, 16'h0000);
    redirect_en = 1'b1; redirect_addr = 14'd30;
    step();
    redirect_en = 1'b0;
    @(negedge clk);
    chk(!ins_valid && mem_addr == 30, "R8", "waiting instruction dropped by redirect",
        {ins_valid, 15'h0, 16'(mem_addr)}, 32'd30);
    man_dn = 1'b1;
    step();
    wait_halt("R5");
    chk(expq.size() == 0, "R7", "target instruction taken once", expq.size(), 32'h0);
    // R5: redirect ignored once halted
    redirect_en = 1'b1; redirect_addr = 14'd5;
    step(); step();
    redirect_en = 1'b0;
    @(negedge clk);
    chk(halted && !mem_req && mem_addr == 33, "R5", "redirect ignored after halt",
        {halted, mem_req, 14'h0, 16'(mem_addr)}, 32'h80000021);

    // wrap of the fetch address across the top
    clear_mem(); expq.delete();
    put(63, 8'h3E); put(0, 8'h5C); put(1, 8'h01);
    push_exp(8'h3E, 8'h5C, 16'h0000);
    man_rdy = 1'b0; man_dn = 1'b1;
    do_reset();
    step();
    redirect_en = 1'b1; redirect_addr = '1;
    step();
    redirect_en = 1'b0;
    @(negedge clk);
    chk(mem_addr == 14'h3FFF && mem_req, "R6", "request held at top address",
        {mem_req, 15'h0, 16'(mem_addr)}, 32'h80003FFF);
    step();
    @(negedge clk);
    chk(mem_addr == 14'h3FFF, "R6", "address holds while memory not ready",
        32'(mem_addr), 32'h3FFF);
    man_rdy = 1'b1;
    step();
    wait_halt("R5");
    chk(mem_addr == 2, "R6", "address wrapped past top", 32'(mem_addr), 32'd2);
    chk(expq.size() == 0, "R2", "wrapped immediate instruction issued", expq.size(), 32'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule